// File: doc/BRIEF.md
# CCD Correlated-Sampling Strobe Sequencer

This block produces the per-pixel control strobes for an external correlated-double-sampling converter that sits behind a CCD sensor. Each pixel-period trigger from the CCD clock generator starts one sequence with three steps. First the reference-hold line stays low so the sampler can acquire the reset reference. Then the line goes high to freeze that reference while the pixel level settles. Then the start-convert line pulses high and the converter begins a conversion on its rising edge. The reference-hold line returns low together with the falling edge of start-convert, so the sampler is never released before a conversion has been launched.

A two-bit rate selector picks one of four pixel rates: 10 MHz, 5 MHz, 3 MHz and 1.2 MHz. Each rate has its own acquisition time, settling time and pixel period, and its own analog bandwidth code, which is driven to the converter. All durations are converted to clock-cycle counts at elaboration from a clock-period parameter, and every count is rounded up. The selector is sampled only when a trigger is accepted, so a rate change never takes effect inside a running sequence.

A one-clock conversion-issued pulse marks each start-convert rising edge, so downstream logic can capture the result. A trigger that arrives while a sequence is still running is dropped and sets a sticky overrun flag.

Top module: `ccd_cds_sequencer`

## Requirements
- R1: The bandwidth code `bw_sel` equals the rate code latched for the current sequence. The codes are 2'b00 for 10 MHz (100 ns period), 2'b01 for 5 MHz (200 ns), 2'b10 for 3 MHz (333 ns) and 2'b11 for 1.2 MHz (833 ns).
- R2: `rate_sel` is sampled only on the clock edge that accepts a trigger. At any other time, changing it alters neither `bw_sel` nor the timing of the sequence in progress.
- R3: Before each rising edge of `ref_hold`, the line has been low for at least ceil(T_acq / T_clk) consecutive cycles. T_acq is 40, 80, 150 or 300 ns for rate codes 0 to 3.
- R4: From the rising edge of `ref_hold` to the rising edge of `start_conv`, `ref_hold` has been high for at least ceil(T_set / T_clk) cycles. T_set is 40, 80, 150 or 300 ns for rate codes 0 to 3.
- R5: `start_conv` stays high for exactly ceil(20 ns / T_clk) cycles. `ref_hold` is high whenever `start_conv` is high, and it falls in the same cycle as `start_conv`.
- R6: An accepted sequence lasts max(ceil(T_period / T_clk), A+S+P) cycles, where A, S and P are the acquisition, settling and pulse counts. It begins in the cycle after the accepting edge, with `ref_hold` low for its first A cycles. Outside a sequence all strobes are low.
- R7: `conv_issued` is high for exactly one cycle, the first cycle in which `start_conv` is high, and at no other time.
- R8: A trigger is accepted when the block is idle, or in the last cycle of a sequence (a back-to-back restart). A trigger at any other time during a sequence is ignored and sets `overrun`, which then stays high until reset.
- R9: While `en` is low, triggers are neither accepted nor counted as overruns. A sequence that is already running completes unchanged.
- R10: During and directly after reset, `ref_hold`, `start_conv`, `conv_issued` and `overrun` are low and `bw_sel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows triggers to be accepted |
| rate_sel | input | 2 | Requested pixel rate code |
| pix_trig | input | 1 | Pixel-period trigger, sampled on each rising clock edge |
| ref_hold | output | 1 | Reference hold strobe, high means hold |
| start_conv | output | 1 | Start-convert strobe, conversion begins on its rising edge |
| bw_sel | output | 2 | Analog bandwidth code for the current rate |
| conv_issued | output | 1 | One-cycle pulse at each start-convert rising edge |
| overrun | output | 1 | Sticky flag, set when a trigger was ignored during a sequence |

## Verification
The end of one sequence and the acceptance of the next trigger can fall in the same cycle. A rate change can be applied in that same cycle, so the old rate's last count and the new rate's first count meet at one edge. The bench provokes this in two ways: by triggers spaced exactly one sequence length apart, with the rate code stepping between groups, and by a long random phase with dense triggers. It judges the result cycle by cycle against a behavioural model. Run-length monitors confirm that the acquisition low time and the hold-to-convert time stay at their minimums across every restart.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  localparam int unsigned RATE_W = 2;
  localparam int unsigned NRATE  = 1 << RATE_W;

  typedef enum logic [RATE_W-1:0] {
    RATE_10M  = 2'd0,
    RATE_5M   = 2'd1,
    RATE_3M   = 2'd2,
    RATE_1M2  = 2'd3
  } rate_e;

  // minimum low time of the hold line before it rises
  function automatic int unsigned acq_ns(input int unsigned r);
    case (r)
      0:       return 40;
      1:       return 80;
      2:       return 150;
      default: return 300;
    endcase
  endfunction

  // minimum hold-high time before the convert edge
  function automatic int unsigned settle_ns(input int unsigned r);
    case (r)
      0:       return 40;
      1:       return 80;
      2:       return 150;
      default: return 300;
    endcase
  endfunction

  function automatic int unsigned period_ns(input int unsigned r);
    case (r)
      0:       return 100;
      1:       return 200;
      2:       return 333;
      default: return 833;
    endcase
  endfunction

  // ceiling division, so that no minimum time is shortened
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned active_cycles(input int unsigned r,
                                                input int unsigned clk_ps,
                                                input int unsigned pulse_ns);
    return ns_to_cycles(acq_ns(r), clk_ps) + ns_to_cycles(settle_ns(r), clk_ps)
         + ns_to_cycles(pulse_ns, clk_ps);
  endfunction

  function automatic int unsigned seq_cycles(input int unsigned r,
                                             input int unsigned clk_ps,
                                             input int unsigned pulse_ns);
    int unsigned per;
    int unsigned act;
    per = ns_to_cycles(period_ns(r), clk_ps);
    act = active_cycles(r, clk_ps, pulse_ns);
    return (per > act) ? per : act;
  endfunction

  function automatic int unsigned max_seq_cycles(input int unsigned clk_ps,
                                                 input int unsigned pulse_ns);
    int unsigned m;
    m = 1;
    for (int unsigned r = 0; r < NRATE; r++) begin
      if (seq_cycles(r, clk_ps, pulse_ns) > m) m = seq_cycles(r, clk_ps, pulse_ns);
    end
    return m;
  endfunction

endpackage

// File: rtl/seq_rate_table.sv
module seq_rate_table
  import ccd_seq_pkg::*;
#(
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned PULSE_NS = 20,
  parameter int unsigned CW       = 7
) (
  input  logic [RATE_W-1:0] rate,
  output logic [CW-1:0]     b_hold,
  output logic [CW-1:0]     b_conv,
  output logic [CW-1:0]     b_done,
  output logic [CW-1:0]     b_last
);

  logic [CW-1:0] hold_tab [NRATE];
  logic [CW-1:0] conv_tab [NRATE];
  logic [CW-1:0] done_tab [NRATE];
  logic [CW-1:0] last_tab [NRATE];

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    localparam int unsigned A   = ns_to_cycles(acq_ns(g), CLK_PS);
    localparam int unsigned S   = ns_to_cycles(settle_ns(g), CLK_PS);
    localparam int unsigned P   = ns_to_cycles(PULSE_NS, CLK_PS);
    localparam int unsigned LEN = seq_cycles(g, CLK_PS, PULSE_NS);
    assign hold_tab[g] = CW'(A);
    assign conv_tab[g] = CW'(A + S);
    assign done_tab[g] = CW'(A + S + P);
    assign last_tab[g] = CW'(LEN - 1);
  end

  assign b_hold = hold_tab[rate];
  assign b_conv = conv_tab[rate];
  assign b_done = done_tab[rate];
  assign b_last = last_tab[rate];

endmodule

// File: rtl/seq_phase_counter.sv
module seq_phase_counter #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trig,
  input  logic [CW-1:0] b_last,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic          accept,
  output logic          rejected,
  output logic          ovr
);

  logic seq_last;

  assign seq_last = active && (cnt == b_last);
  assign accept   = en && trig && (!active || seq_last);
  assign rejected = en && trig && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      ovr    <= 1'b0;
    end else begin
      if (accept) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (seq_last) active <= 1'b0;
        else          cnt    <= cnt + 1'b1;
      end
      if (rejected) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode #(
  parameter int unsigned CW = 7
) (
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] b_hold,
  input  logic [CW-1:0] b_conv,
  input  logic [CW-1:0] b_done,
  output logic          hold,
  output logic          conv,
  output logic          issued
);

  logic before_done;

  assign before_done = cnt < b_done;
  assign hold   = active && (cnt >= b_hold) && before_done;
  assign conv   = active && (cnt >= b_conv) && before_done;
  assign issued = active && (cnt == b_conv);

endmodule

// File: rtl/ccd_cds_sequencer.sv
module ccd_cds_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned PULSE_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pix_trig,
  output logic              ref_hold,
  output logic              start_conv,
  output logic [RATE_W-1:0] bw_sel,
  output logic              conv_issued,
  output logic              overrun
);

  localparam int unsigned MAXLEN = max_seq_cycles(CLK_PS, PULSE_NS);
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  logic [RATE_W-1:0] cur_rate;
  logic [CW-1:0]     b_hold, b_conv, b_done, b_last;
  logic [CW-1:0]     cnt;
  logic              active, accept, rejected;

  seq_rate_table #(.CLK_PS(CLK_PS), .PULSE_NS(PULSE_NS), .CW(CW)) u_tab (
    .rate   (cur_rate),
    .b_hold (b_hold),
    .b_conv (b_conv),
    .b_done (b_done),
    .b_last (b_last)
  );

  seq_phase_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .trig     (pix_trig),
    .b_last   (b_last),
    .active   (active),
    .cnt      (cnt),
    .accept   (accept),
    .rejected (rejected),
    .ovr      (overrun)
  );

  // rate is latched only at the pixel boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_rate <= '0;
    else if (accept) cur_rate <= rate_sel;
  end

  seq_strobe_decode #(.CW(CW)) u_dec (
    .active (active),
    .cnt    (cnt),
    .b_hold (b_hold),
    .b_conv (b_conv),
    .b_done (b_done),
    .hold   (ref_hold),
    .conv   (start_conv),
    .issued (conv_issued)
  );

  assign bw_sel = cur_rate;

endmodule

// File: rtl/ccd_cds_sequencer_chk.sv
module ccd_cds_sequencer_chk
  import ccd_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              conv,
  input logic              issued,
  input logic [RATE_W-1:0] bw,
  input logic              ovr,
  input logic              accept,
  input logic              active,
  input logic              rejected
);

  AST_BW_ONLY_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(bw)); // R2

  AST_CONV_INSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> hold); // R5

  AST_HOLD_DROPS_WITH_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $fell(conv)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!hold && !conv && !issued)); // R6

  AST_ISSUE_IS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    issued |-> $rose(conv)); // R7

  AST_RISE_IS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv) |-> issued); // R7

  AST_OVR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |=> ovr); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr); // R8

endmodule

bind ccd_cds_sequencer ccd_cds_sequencer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold     (ref_hold),
  .conv     (start_conv),
  .issued   (conv_issued),
  .bw       (bw_sel),
  .ovr      (overrun),
  .accept   (accept),
  .active   (active),
  .rejected (rejected)
);

// File: tb/sim_ccd_cds_sequencer.sv
`timescale 1ns/1ps
module sim_ccd_cds_sequencer;

  localparam int CLK_NS   = 10;
  localparam int CLK_PS   = CLK_NS * 1000;
  localparam int PULSE_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       pix_trig = 1'b0;
  logic       ref_hold, start_conv, conv_issued, overrun;
  logic [1:0] bw_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_NS/2.0) clk = ~clk;

  ccd_cds_sequencer #(.CLK_PS(CLK_PS), .PULSE_NS(PULSE_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel), .pix_trig(pix_trig),
    .ref_hold(ref_hold), .start_conv(start_conv), .bw_sel(bw_sel),
    .conv_issued(conv_issued), .overrun(overrun)
  );

  // timing figures restated per rate, counted up cycle by cycle
  function automatic int ns_of(input int kind, input int r);
    int t [3][4];
    t[0] = '{40, 80, 150, 300};
    t[1] = '{40, 80, 150, 300};
    t[2] = '{100, 200, 333, 833};
    return t[kind][r];
  endfunction

  function automatic int cyc(input int ns);
    int c = 0;
    while (c * CLK_PS < ns * 1000) c++;
    return c;
  endfunction

  function automatic int n_acq(input int r);  return cyc(ns_of(0, r)); endfunction
  function automatic int n_set(input int r);  return cyc(ns_of(1, r)); endfunction
  function automatic int n_pul();             return cyc(PULSE_NS);    endfunction
  function automatic int n_len(input int r);
    int busy = n_acq(r) + n_set(r) + n_pul();
    return (cyc(ns_of(2, r)) > busy) ? cyc(ns_of(2, r)) : busy;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_act;
  int m_t;
  int m_rate;
  bit m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_rate = 0; m_ovr = 0;
    end else begin
      bit at_end;
      at_end = m_act && (m_t == n_len(m_rate) - 1);
      if (en && pix_trig && (!m_act || at_end)) begin
        m_act = 1; m_t = 0; m_rate = int'(rate_sel);
      end else begin
        if (en && pix_trig) m_ovr = 1;
        if (m_act) begin
          if (at_end) m_act = 0;
          else m_t++;
        end
      end
    end
  end

  // per-cycle comparison and run-length monitors
  int  low_run = 0, high_run = 0, conv_run = 0;
  bit  p_hold = 0, p_conv = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      low_run = 0; high_run = 0; conv_run = 0; p_hold = 0; p_conv = 0;
    end else begin
      int a, s, d;
      a = n_acq(m_rate); s = n_set(m_rate); d = a + s + n_pul();
      check("R6 ref_hold", int'(ref_hold), int'(m_act && m_t >= a && m_t < d));
      check("R5 start_conv", int'(start_conv), int'(m_act && m_t >= a + s && m_t < d));
      check("R7 conv_issued", int'(conv_issued), int'(m_act && m_t == a + s));
      check("R1 bw_sel", int'(bw_sel), m_rate);
      check("R8 overrun", int'(overrun), int'(m_ovr));
      if (ref_hold && !p_hold) check("R3 acquisition low run", int'(low_run >= n_acq(int'(bw_sel))), 1);
      if (start_conv && !p_conv) check("R4 settle before convert", int'(high_run >= n_set(int'(bw_sel))), 1);
      if (!start_conv && p_conv) begin
        check("R5 convert width", conv_run, n_pul());
        check("R5 hold falls with convert", int'(ref_hold), 0);
      end
      if (ref_hold) begin high_run++; low_run = 0; end
      else begin low_run++; high_run = 0; end
      if (start_conv) conv_run++; else conv_run = 0;
      p_hold = ref_hold; p_conv = start_conv;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_trig = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10 hold in reset", int'(ref_hold), 0);
    check("R10 conv in reset", int'(start_conv), 0);
    check("R10 issued in reset", int'(conv_issued), 0);
    check("R10 overrun in reset", int'(overrun), 0);
    check("R10 bw in reset", int'(bw_sel), 0);
    rst_n = 1'b1;
  endtask

  task automatic trig_once(input int r);
    @(negedge clk);
    rate_sel = 2'(r); pix_trig = 1'b1;
    @(negedge clk);
    pix_trig = 1'b0;
  endtask

  initial begin
    en = 1'b1;
    do_reset();
    repeat (3) @(negedge clk);
    check("R10 idle after reset", int'(ref_hold | start_conv | overrun), 0);

    // back-to-back pixels at each rate, spaced by exactly one sequence length
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) begin
        trig_once(r);
        repeat (n_len(r) - 2) @(negedge clk);
      end
    end
    repeat (100) @(negedge clk);
    check("R8 no overrun on exact spacing", int'(overrun), 0);

    // rate change inside a sequence, then an early trigger
    trig_once(3);
    rate_sel = 2'd0;
    repeat (10) @(negedge clk);
    check("R2 bw unchanged mid-sequence", int'(bw_sel), 3);
    trig_once(1);
    @(negedge clk);
    check("R8 early trigger flagged", int'(overrun), 1);
    check("R2 early trigger kept rate", int'(bw_sel), 3);
    repeat (120) @(negedge clk);

    // enable low ignores triggers; a running sequence completes
    do_reset();
    en = 1'b0;
    for (int k = 0; k < 5; k++) trig_once(2);
    repeat (5) @(negedge clk);
    check("R9 no sequence when disabled", int'(ref_hold), 0);
    check("R9 no overrun when disabled", int'(overrun), 0);
    en = 1'b1;
    trig_once(2);
    en = 1'b0;
    repeat (16) @(negedge clk);
    check("R9 sequence runs after enable drop", int'(ref_hold), 1);
    trig_once(0);
    check("R9 disabled trigger not flagged", int'(overrun), 0);
    repeat (60) @(negedge clk);
    en = 1'b1;

    // random phase: dense triggers, rate changes, occasional disable
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      pix_trig = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 15) == 0) rate_sel = 2'($urandom_range(0, 3));
      en = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 999) == 0) do_reset();
    end
    pix_trig = 1'b0;
    en = 1'b1;
    repeat (100) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule